// File: doc/BRIEF.md
# Irregular-Sequence Modulo-20 Counter

This block is a synchronous 5-bit counter that does not count in plain binary. It cycles through a fixed list of twenty code values and then starts again at zero. It has a clock, a synchronous active-high reset and a count enable. It drives the present code, plus a wrap flag that marks the step from the final code back to the first.

The next state of each bit is a separate equation over the present code. Each equation is written as the set of present codes that drive that bit high. One parameter picks how the state is stored. The first choice loads each bit like a D flip-flop. The second computes a J and a K input for each bit and applies the JK characteristic rule. The two choices give the same sequence cycle by cycle. The twelve codes that are not in the list can only be reached by upsetting the register. From any of them the counter returns to zero on the next enabled edge, so a simulation never wanders.

Top module: `irrseq_counter`

## Requirements
- R1: The state is 5 bits wide. When `rst` is high at a rising edge, the state becomes 0, whatever the value of `en`.
- R2: With `rst` low and `en` low, a rising edge leaves the state unchanged. This includes a state that is not in the list.
- R3: With `rst` low and `en` high, each rising edge moves the state one place along the cyclic order 0, 1, 2, 3, 4, 5, 6, 7, 11, 12, 13, 15, 16, 19, 22, 23, 24, 26, 27, 31. After 31 the state returns to 0, so twenty enabled edges bring any listed code back to itself.
- R4: The step that follows 7 lands on 11. Starting from reset, codes 8, 9 and 10 and every other unlisted code never appear, whatever pattern of enable and reset is applied.
- R5: The codes 8, 9, 10, 14, 17, 18, 20, 21, 25, 28, 29 and 30 are outside the list. From any of them, the next edge with `en` high and `rst` low gives state 0.
- R6: `wrap` is a combinational output. It is 1 exactly when the state is 31, `en` is 1 and `rst` is 0. Each pass through the whole list raises it for one cycle.
- R7: With `USE_JK` = 0 the bits are stored as D-type registers. With `USE_JK` = 1 they are stored as JK-type registers. For the same input history, both give the same `code` and `wrap` on every cycle.
- R8: In the JK choice, a bit whose code must change gets J=1, K=0 when it rises and J=0, K=1 when it falls. A bit that keeps its value gets J=K=0. J and K are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to code 0, active high, overrides `en` |
| en | input | 1 | Count enable; when low the state holds |
| code | output | 5 | Present state code, bit 4 most significant |
| wrap | output | 1 | High while the state is 31 and an enabled step is pending |

## Verification
The properties assume that `rst` and `en` are synchronous to `clk` and have known values at every rising edge. The bench drives both a fixed time after each falling edge, from a seeded random stream mixed with directed runs. The properties also assume that the state changes only through the block's own next-state logic. Unlisted codes cannot be reached through the ports. The bench therefore places each one directly in the state register on the cycle that follows a reset edge, when every property attempt is disabled. After that, only enabled or held steps are checked.

// File: rtl/irrseq_pkg.sv
package irrseq_pkg;

  localparam int CODE_W     = 5;
  localparam int CODE_SPACE = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t FIRST_CODE = '0;
  localparam code_t LAST_CODE  = code_t'(CODE_SPACE - 1);

  // For each bit: set of present codes whose successor has that bit high.
  localparam logic [CODE_SPACE-1:0] SUCC_ONES_B4 = 32'h0DC9_8000;
  localparam logic [CODE_SPACE-1:0] SUCC_ONES_B3 = 32'h0D80_3880;
  localparam logic [CODE_SPACE-1:0] SUCC_ONES_B2 = 32'h0848_3878;
  localparam logic [CODE_SPACE-1:0] SUCC_ONES_B1 = 32'h0D49_20E6;
  localparam logic [CODE_SPACE-1:0] SUCC_ONES_B0 = 32'h0C41_30D5;

  // Codes that belong to the twenty-entry cycle.
  localparam logic [CODE_SPACE-1:0] LISTED_SET   = 32'h8DC9_B8FF;

  // Per-bit next-state equation, sum of present-state minterms.
  function automatic logic succ_bit(int b, code_t c);
    case (b)
      0:       return SUCC_ONES_B0[c];
      1:       return SUCC_ONES_B1[c];
      2:       return SUCC_ONES_B2[c];
      3:       return SUCC_ONES_B3[c];
      4:       return SUCC_ONES_B4[c];
      default: return 1'b0;
    endcase
  endfunction

  function automatic code_t succ_code(code_t c);
    code_t n;
    for (int b = 0; b < CODE_W; b++) n[b] = succ_bit(b, c);
    return n;
  endfunction

  function automatic logic is_listed(code_t c);
    return LISTED_SET[c];
  endfunction

endpackage

// File: rtl/irrseq_d_core.sv
module irrseq_d_core
  import irrseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output code_t q
);

  code_t st_q;
  code_t d_w;

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign d_w[b] = en ? succ_bit(b, st_q) : st_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FIRST_CODE;
    else     st_q <= d_w;
  end

  assign q = st_q;

  // R2
  d_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st_q));

  // R3
  d_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && is_listed(st_q)) |=> (st_q != $past(st_q)));

endmodule

// File: rtl/irrseq_jk_exc.sv
module irrseq_jk_exc (
  input  logic q_now,
  input  logic q_tgt,
  output logic j,
  output logic k
);

  // Excitation from present and wanted value: set, clear or hold.
  assign j = ~q_now &  q_tgt;
  assign k =  q_now & ~q_tgt;

endmodule

// File: rtl/irrseq_jk_core.sv
module irrseq_jk_core
  import irrseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output code_t q
);

  code_t st_q;
  code_t tgt_w;
  code_t j_w;
  code_t k_w;

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign tgt_w[b] = en ? succ_bit(b, st_q) : st_q[b];
    irrseq_jk_exc u_exc (
      .q_now (st_q[b]),
      .q_tgt (tgt_w[b]),
      .j     (j_w[b]),
      .k     (k_w[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= FIRST_CODE;
    end else begin
      for (int b = 0; b < CODE_W; b++) begin
        case ({j_w[b], k_w[b]})
          2'b10:   st_q[b] <= 1'b1;
          2'b01:   st_q[b] <= 1'b0;
          2'b11:   st_q[b] <= ~st_q[b];
          default: st_q[b] <= st_q[b];
        endcase
      end
    end
  end

  assign q = st_q;

  // R8
  jk_no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (j_w & k_w) == '0);

  // R8
  jk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (j_w == '0 && k_w == '0));

endmodule

// File: rtl/irrseq_wrap_flag.sv
module irrseq_wrap_flag
  import irrseq_pkg::*;
(
  input  logic  rst,
  input  logic  en,
  input  code_t code,
  output logic  wrap
);

  assign wrap = en & ~rst & (code == LAST_CODE);

endmodule

// File: rtl/irrseq_counter.sv
module irrseq_counter
  import irrseq_pkg::*;
#(
  parameter bit USE_JK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [CODE_W-1:0] code,
  output logic              wrap
);

  code_t code_w;
  logic  wrap_w;

  if (!USE_JK) begin : g_dff
    irrseq_d_core u_core (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .q   (code_w)
    );
  end else begin : g_jkff
    irrseq_jk_core u_core (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .q   (code_w)
    );
  end

  irrseq_wrap_flag u_wrap (
    .rst  (rst),
    .en   (en),
    .code (code_w),
    .wrap (wrap_w)
  );

  assign code = code_w;
  assign wrap = wrap_w;

  // R4
  listed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (en && is_listed(code_w)) |=> is_listed(code_w));

  // R5
  unlisted_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !is_listed(code_w)) |=> (code_w == FIRST_CODE));

  // R6
  wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> (code_w == FIRST_CODE));

endmodule

// File: tb/irrseq_counter_test.sv
module irrseq_counter_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [4:0] code_d, code_jk;
  logic       wrap_d, wrap_jk;

  always #2.5 clk = ~clk;

  irrseq_counter #(.USE_JK(1'b0)) uut (
    .clk(clk), .rst(rst), .en(en), .code(code_d), .wrap(wrap_d));

  irrseq_counter #(.USE_JK(1'b1)) uut_jk (
    .clk(clk), .rst(rst), .en(en), .code(code_jk), .wrap(wrap_jk));

  localparam logic [4:0] ORDER [20] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4,
    5'd5, 5'd6, 5'd7, 5'd11, 5'd12, 5'd13, 5'd15, 5'd16, 5'd19, 5'd22,
    5'd23, 5'd24, 5'd26, 5'd27, 5'd31};

  int         checks = 0;
  int         fails  = 0;
  int         wraps  = 0;
  logic [4:0] model  = 5'd0;
  string      tag    = "R1";
  logic [4:0] frc_val = 5'd0;

  function automatic int find_pos(logic [4:0] c);
    for (int i = 0; i < 20; i++) if (ORDER[i] == c) return i;
    return -1;
  endfunction

  function automatic logic [4:0] exp_next(logic [4:0] c);
    int p;
    p = find_pos(c);
    if (p < 0) return 5'd0;
    return ORDER[(p + 1) % 20];
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic check_state();
    check(tag, int'(code_d), int'(model));
    check("R8", int'(code_jk), int'(model));
    check("R7", int'(code_jk), int'(code_d));
  endtask

  // One cycle: check the state left by the last edge, then drive inputs.
  task automatic cyc(logic r, logic e, string t);
    logic w;
    @(negedge clk);
    #1;
    check_state();
    rst = r;
    en  = e;
    #0.5;
    w = !r && e && (model == 5'd31);
    check("R6", int'(wrap_d), int'(w));
    check("R7", int'(wrap_jk), int'(wrap_d));
    if (w) wraps++;
    model = r ? 5'd0 : (e ? exp_next(model) : model);
    tag = t;
  endtask

  // Place an unlisted code right after a reset edge.
  task automatic unlisted_start(logic [4:0] c, logic hold_first);
    cyc(1'b1, 1'b0, "R1");
    @(negedge clk);
    #1;
    check_state();
    frc_val = c;
    force uut.g_dff.u_core.st_q = frc_val;
    force uut_jk.g_jkff.u_core.st_q = frc_val;
    #0.3;
    release uut.g_dff.u_core.st_q;
    release uut_jk.g_jkff.u_core.st_q;
    #0.2;
    check("R5", int'(code_d), int'(c));
    check("R5", int'(code_jk), int'(c));
    rst = 1'b0;
    en  = !hold_first;
    #0.2;
    check("R6", int'(wrap_d), 0);
    check("R7", int'(wrap_jk), 0);
    model = hold_first ? c : 5'd0;
    tag   = hold_first ? "R2" : "R5";
    if (hold_first) cyc(1'b0, 1'b1, "R5");
  endtask

  initial begin
    logic [4:0] bad [12];
    logic r, e;
    bad = '{5'd8, 5'd9, 5'd10, 5'd14, 5'd17, 5'd18,
            5'd20, 5'd21, 5'd25, 5'd28, 5'd29, 5'd30};
    void'($urandom(32'd1357));

    // R1: reset state, and reset winning over enable
    cyc(1'b1, 1'b0, "R1");
    cyc(1'b1, 1'b1, "R1");

    // R3 / R4: two full passes, with the 7 -> 11 step tagged
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, "R3");
    cyc(1'b0, 1'b1, "R4");
    for (int i = 0; i < 32; i++) cyc(1'b0, 1'b1, "R3");
    cyc(1'b0, 1'b0, "R2");
    check("R6", wraps, 2);
    check("R3", int'(code_d), 0);

    // R2: hold in the middle of the list
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, "R3");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R2");
    for (int i = 0; i < 11; i++) cyc(1'b0, 1'b1, "R3");

    // Random enable and rare reset
    for (int i = 0; i < 3000; i++) begin
      r = (($urandom % 50) == 0);
      e = (($urandom % 4) != 0);
      cyc(r, e, r ? "R1" : (e ? "R3" : "R2"));
    end

    // R5: every unlisted start code
    for (int i = 0; i < 12; i++) unlisted_start(bad[i], (i % 2) == 0);

    cyc(1'b0, 1'b0, "R2");
    cyc(1'b0, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule